// File: doc/BRIEF.md
# Flash Busy-Status Poller

This block waits for a serial flash to finish an internal operation. After a one-cycle request it selects the flash and sends a read-status opcode, optionally followed by dummy bytes. It then reads status bytes until the chosen busy bit shows the device idle, and signals completion with a one-cycle done pulse. If the request says that an erase or erase-resume command has just been issued, a programmable hold-off must pass before chip select first goes low.

The serial clock runs at half the system clock. Each bit slot is two cycles: one with the clock low, during which outputs change, and one with the clock high. The flash samples on the rising edge, and the poller samples received data at the end of the high phase. The opcode phase and the receive phase each have their own lane setting. The dummy phase uses the opcode lanes. In continuous mode chip select stays low and status bytes stream back to back. In split mode every poll is its own chip-select frame, with a fixed idle gap between frames.

The controller has six states. `ST_IDLE` goes to `ST_HOLD` on a request with the erase flag set and a nonzero delay, and to `ST_CMD` on any other request. `ST_HOLD` goes to `ST_CMD` when the delay expires. `ST_CMD` goes to `ST_DUMMY` when dummy bytes are enabled, and to `ST_RECV` when they are not. `ST_DUMMY` goes to `ST_RECV` after its last byte. At the end of each byte, `ST_RECV` does one of three things: it goes to `ST_IDLE` when the byte shows idle, to `ST_GAP` in split mode, or stays in `ST_RECV` in continuous mode. `ST_GAP` goes to `ST_CMD` when the gap count runs out.

Top module: `flash_busy_poller`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, all lane enables are 0, done is 0, busy is 0 and the status output is 0.
- R2: The opcode is sent MSB first on the opcode lanes, selected by a lane code: 0 = one lane (io0), 1 = two lanes (io1 carries the higher bit), 2 or 3 = four lanes (io3 highest). Only those lanes are enabled. Data changes while the clock is low.
- R3: When dummy bytes are enabled, (count field + 1) dummy bytes follow the opcode on the opcode lanes, all bits equal to the dummy-value setting. When they are disabled, no dummy bytes are sent.
- R4: Status bytes are sampled MSB first with all lane enables at 0. Code 0 reads io1, code 1 reads io[1:0] and codes 2 or 3 read io[3:0].
- R5: A status byte shows idle when the bit at the 3-bit busy position differs from the 1-bit busy level.
- R6: In continuous mode, polling uses one chip-select frame with a single opcode, then as many status bytes as it takes to reach the first idle byte.
- R7: In split mode, each status byte comes in its own frame that repeats the opcode and dummy bytes. Chip select is high for GAP_CYC cycles between frames.
- R8: Done is a one-cycle pulse issued in the same cycle that the idle status byte appears on the status output, with chip select already high. It occurs exactly once per request.
- R9: A request with the erase flag set and a nonzero delay D brings chip select low D cycles later than a request without the flag would. A delay of 0, or a request without the flag, adds no delay.
- R10: A request that arrives while a poll is in progress is ignored.
- R11: The status output takes the value of every captured byte and changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle poll request |
| after_erase | input | 1 | Sampled with start: an erase or resume command was just issued |
| cfg_opcode | input | 8 | Read-status opcode |
| cfg_cmd_mode | input | 2 | Lane code for the opcode and dummy phases |
| cfg_rx_mode | input | 2 | Lane code for the receive phase |
| cfg_busy_pos | input | 3 | Bit index of the busy flag |
| cfg_busy_level | input | 1 | Value of the busy flag while the device is busy |
| cfg_dmy_en | input | 1 | Enable dummy bytes after the opcode |
| cfg_dmy_cnt | input | DMY_W | Number of dummy bytes minus one |
| cfg_dmy_val | input | 1 | Level driven during dummy bytes |
| cfg_split | input | 1 | One frame per poll |
| cfg_erase_dly | input | DLY_W | Hold-off after an erase, in clock cycles |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_io_o | output | 4 | Lane output data |
| spi_io_oe | output | 4 | Lane output enables |
| spi_io_i | input | 4 | Lane input data |
| poll_busy | output | 1 | A request is being served |
| poll_done | output | 1 | Completion pulse |
| poll_status | output | 8 | Last captured status byte |

## Verification
The hardest case to reach is a long poll. It needs several busy bytes under an arbitrary busy position and level, in either framing mode and with mixed lane codes, and it needs a second request that lands in the middle of the transfer. The bench models a flash that answers with a generated byte sequence. In each sequence the chosen bit is forced to the busy level for a random number of bytes and then flipped. The bench injects a second request, with the erase flag set, partway through some polls. It checks that this request changes neither the frame count, nor the clock count, nor the number of done pulses.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

    localparam int BYTE_W = 8;
    localparam int LANE_N = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_CMD,
        ST_DUMMY,
        ST_RECV,
        ST_GAP
    } poll_state_e;

    // index of the last bit slot of one byte for a lane code
    function automatic logic [2:0] last_slot(input logic [1:0] mode);
        case (mode)
            2'd0:    last_slot = 3'd7;
            2'd1:    last_slot = 3'd3;
            default: last_slot = 3'd1;
        endcase
    endfunction

    function automatic logic [LANE_N-1:0] lane_mask(input logic [1:0] mode);
        case (mode)
            2'd0:    lane_mask = 4'b0001;
            2'd1:    lane_mask = 4'b0011;
            default: lane_mask = 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/bsp_holdoff.sv
module bsp_holdoff #(
    parameter int DLY_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    output logic             active,
    output logic             expire
);
    logic [DLY_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - DLY_W'(1);
    end

    assign active = (cnt_q != '0);
    assign expire = (cnt_q == DLY_W'(1));

    // R9: the hold-off counter only ever steps down by one
    a_r9_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !load) |=> (cnt_q == $past(cnt_q) - DLY_W'(1)));

endmodule

// File: rtl/bsp_shifter.sv
module bsp_shifter
    import bsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_val,
    input  logic              shift_tx,
    input  logic              shift_rx,
    input  logic [1:0]        mode,
    input  logic [LANE_N-1:0] rx_lanes,
    output logic [LANE_N-1:0] tx_lanes,
    output logic [BYTE_W-1:0] rx_next
);
    logic [BYTE_W-1:0] sh_q;
    logic [BYTE_W-1:0] tx_next;

    always_comb begin
        case (mode)
            2'd0: begin
                tx_lanes = {3'b000, sh_q[7]};
                tx_next  = {sh_q[6:0], 1'b0};
                rx_next  = {sh_q[6:0], rx_lanes[1]};
            end
            2'd1: begin
                tx_lanes = {2'b00, sh_q[7:6]};
                tx_next  = {sh_q[5:0], 2'b00};
                rx_next  = {sh_q[5:0], rx_lanes[1:0]};
            end
            default: begin
                tx_lanes = sh_q[7:4];
                tx_next  = {sh_q[3:0], 4'b0000};
                rx_next  = {sh_q[3:0], rx_lanes};
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sh_q <= '0;
        else if (load)     sh_q <= load_val;
        else if (shift_rx) sh_q <= rx_next;
        else if (shift_tx) sh_q <= tx_next;
    end

endmodule

// File: rtl/flash_busy_poller.sv
module flash_busy_poller
    import bsp_pkg::*;
#(
    parameter int DLY_W   = 7,
    parameter int DMY_W   = 4,
    parameter int GAP_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             after_erase,
    input  logic [7:0]       cfg_opcode,
    input  logic [1:0]       cfg_cmd_mode,
    input  logic [1:0]       cfg_rx_mode,
    input  logic [2:0]       cfg_busy_pos,
    input  logic             cfg_busy_level,
    input  logic             cfg_dmy_en,
    input  logic [DMY_W-1:0] cfg_dmy_cnt,
    input  logic             cfg_dmy_val,
    input  logic             cfg_split,
    input  logic [DLY_W-1:0] cfg_erase_dly,
    output logic             spi_sck,
    output logic             spi_cs_n,
    output logic [3:0]       spi_io_o,
    output logic [3:0]       spi_io_oe,
    input  logic [3:0]       spi_io_i,
    output logic             poll_busy,
    output logic             poll_done,
    output logic [7:0]       poll_status
);
    localparam int GAP_W = $clog2(GAP_CYC + 1);

    poll_state_e       state_q, state_d;
    logic              ph_q, ph_d;
    logic [2:0]        slot_q, slot_d;
    logic [DMY_W-1:0]  byte_q, byte_d;
    logic [GAP_W-1:0]  gap_q, gap_d;
    logic [BYTE_W-1:0] status_q;
    logic              done_q;

    logic              hold_load, hold_active, hold_expire;
    logic              sh_load, sh_tx, sh_rx, cap, fin;
    logic [1:0]        cur_mode;
    logic [LANE_N-1:0] tx_lanes;
    logic [BYTE_W-1:0] rx_next;
    logic              slot_end;

    bsp_holdoff #(.DLY_W(DLY_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (hold_load),
        .load_val (cfg_erase_dly),
        .active   (hold_active),
        .expire   (hold_expire)
    );

    bsp_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val (cfg_opcode),
        .shift_tx (sh_tx),
        .shift_rx (sh_rx),
        .mode     (cur_mode),
        .rx_lanes (spi_io_i),
        .tx_lanes (tx_lanes),
        .rx_next  (rx_next)
    );

    assign cur_mode = (state_q == ST_RECV) ? cfg_rx_mode : cfg_cmd_mode;
    assign slot_end = ph_q && (slot_q == last_slot(cur_mode));

    // next-state logic
    always_comb begin
        state_d   = state_q;
        ph_d      = 1'b0;
        slot_d    = slot_q;
        byte_d    = byte_q;
        gap_d     = gap_q;
        hold_load = 1'b0;
        sh_load   = 1'b0;
        sh_tx     = 1'b0;
        sh_rx     = 1'b0;
        cap       = 1'b0;
        fin       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    slot_d = '0;
                    if (after_erase && (cfg_erase_dly != '0)) begin
                        hold_load = 1'b1;
                        state_d   = ST_HOLD;
                    end else begin
                        sh_load = 1'b1;
                        state_d = ST_CMD;
                    end
                end
            end
            ST_HOLD: begin
                if (hold_expire) begin
                    sh_load = 1'b1;
                    state_d = ST_CMD;
                end
            end
            ST_CMD: begin
                ph_d = !ph_q;
                if (ph_q) begin
                    sh_tx = 1'b1;
                    if (slot_end) begin
                        slot_d = '0;
                        byte_d = '0;
                        state_d = cfg_dmy_en ? ST_DUMMY : ST_RECV;
                    end else begin
                        slot_d = slot_q + 3'd1;
                    end
                end
            end
            ST_DUMMY: begin
                ph_d = !ph_q;
                if (ph_q) begin
                    if (slot_end) begin
                        slot_d = '0;
                        if (byte_q == cfg_dmy_cnt) state_d = ST_RECV;
                        else                       byte_d  = byte_q + DMY_W'(1);
                    end else begin
                        slot_d = slot_q + 3'd1;
                    end
                end
            end
            ST_RECV: begin
                ph_d = !ph_q;
                if (ph_q) begin
                    sh_rx = 1'b1;
                    if (slot_end) begin
                        slot_d = '0;
                        cap    = 1'b1;
                        if (rx_next[cfg_busy_pos] != cfg_busy_level) begin
                            fin     = 1'b1;
                            ph_d    = 1'b0;
                            state_d = ST_IDLE;
                        end else if (cfg_split) begin
                            ph_d    = 1'b0;
                            gap_d   = GAP_W'(GAP_CYC - 1);
                            state_d = ST_GAP;
                        end
                    end else begin
                        slot_d = slot_q + 3'd1;
                    end
                end
            end
            ST_GAP: begin
                if (gap_q == '0) begin
                    sh_load = 1'b1;
                    slot_d  = '0;
                    state_d = ST_CMD;
                end else begin
                    gap_d = gap_q - GAP_W'(1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            ph_q     <= 1'b0;
            slot_q   <= '0;
            byte_q   <= '0;
            gap_q    <= '0;
            status_q <= '0;
            done_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ph_q    <= ph_d;
            slot_q  <= slot_d;
            byte_q  <= byte_d;
            gap_q   <= gap_d;
            done_q  <= fin;
            if (cap) status_q <= rx_next;
        end
    end

    // outputs
    always_comb begin
        spi_cs_n  = 1'b1;
        spi_sck   = 1'b0;
        spi_io_o  = '0;
        spi_io_oe = '0;
        unique case (state_q)
            ST_CMD: begin
                spi_cs_n  = 1'b0;
                spi_sck   = ph_q;
                spi_io_oe = lane_mask(cfg_cmd_mode);
                spi_io_o  = tx_lanes;
            end
            ST_DUMMY: begin
                spi_cs_n  = 1'b0;
                spi_sck   = ph_q;
                spi_io_oe = lane_mask(cfg_cmd_mode);
                spi_io_o  = {LANE_N{cfg_dmy_val}} & lane_mask(cfg_cmd_mode);
            end
            ST_RECV: begin
                spi_cs_n = 1'b0;
                spi_sck  = ph_q;
            end
            default: ;
        endcase
        poll_busy   = (state_q != ST_IDLE);
        poll_done   = done_q;
        poll_status = status_q;
    end

    // R8: done lasts one cycle and comes with chip select released
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        poll_done |=> !poll_done);
    a_r8_done_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
        poll_done |-> spi_cs_n);
    // R5: the byte reported with done shows the device idle
    a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        poll_done |-> (poll_status[cfg_busy_pos] != cfg_busy_level));
    // R11: status cannot move while no frame is open
    a_r11_status_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |=> $stable(poll_status));
    // R2: the serial clock only pulses inside a frame
    a_r2_sck_framed: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> !spi_cs_n);
    // R9: no frame opens while the hold-off runs
    a_r9_hold_cs: assert property (@(posedge clk) disable iff (!rst_n)
        hold_active |-> spi_cs_n);

endmodule

// File: tb/flash_busy_poller_test.sv
module flash_busy_poller_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       after_erase = 1'b0;
    logic [7:0] opc = 8'h05;
    logic [1:0] cmd_m = 2'd0, rx_m = 2'd0;
    logic [2:0] pos = 3'd0;
    logic       lvl = 1'b1, den = 1'b0, dval = 1'b0, split = 1'b0;
    logic [3:0] dnum = 4'd0;
    logic [6:0] dly = 7'd0;
    logic       erase = 1'b0;
    logic [3:0] io_in = 4'd0;

    logic       spi_sck, spi_cs_n, poll_busy, poll_done;
    logic [3:0] spi_io_o, spi_io_oe;
    logic [7:0] poll_status;

    always #2 clk = ~clk;

    flash_busy_poller uut (
        .clk(clk), .rst_n(rst_n), .start(start), .after_erase(after_erase),
        .cfg_opcode(opc), .cfg_cmd_mode(cmd_m), .cfg_rx_mode(rx_m),
        .cfg_busy_pos(pos), .cfg_busy_level(lvl), .cfg_dmy_en(den),
        .cfg_dmy_cnt(dnum), .cfg_dmy_val(dval), .cfg_split(split),
        .cfg_erase_dly(dly), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_io_o(spi_io_o), .spi_io_oe(spi_io_oe), .spi_io_i(io_in),
        .poll_busy(poll_busy), .poll_done(poll_done), .poll_status(poll_status)
    );

    int tests = 0, fails = 0, cycles = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int bpl(input logic [1:0] m);
        return (m == 2'd0) ? 1 : (m == 2'd1) ? 2 : 4;
    endfunction
    function automatic logic [3:0] mk(input logic [1:0] m);
        return (m == 2'd0) ? 4'b0001 : (m == 2'd1) ? 4'b0011 : 4'b1111;
    endfunction
    function automatic int pre_slots();
        int cs = 8 / bpl(cmd_m);
        return cs + (den ? (int'(dnum) + 1) * cs : 0);
    endfunction

    // flash model
    logic [7:0] seq [0:7];
    int nbusy = 0;
    int rises = 0, tot_rises = 0, frames = 0;
    int op_err = 0, dmy_err = 0, oe_err = 0;
    logic [7:0] op_cap = 8'd0;

    always @(negedge spi_cs_n) begin
        rises = 0;
        frames++;
        op_cap = 8'd0;
    end

    always @(posedge spi_sck) begin
        int cs, pre;
        cs  = 8 / bpl(cmd_m);
        pre = pre_slots();
        if (rises < cs) begin
            op_cap = 8'((int'(op_cap) << bpl(cmd_m)) | int'(spi_io_o & mk(cmd_m)));
            if (spi_io_oe != mk(cmd_m)) oe_err++;
            if (rises == cs - 1 && op_cap != opc) op_err++;
        end else if (rises < pre) begin
            if ((spi_io_o & mk(cmd_m)) != (dval ? mk(cmd_m) : 4'b0000)) dmy_err++;
            if (spi_io_oe != mk(cmd_m)) dmy_err++;
        end else begin
            if (spi_io_oe != 4'b0000) oe_err++;
        end
        rises++;
        tot_rises++;
    end

    always @(negedge spi_sck) begin
        int pre, k, rsp, idx, sub;
        logic [7:0] b;
        pre = pre_slots();
        if (rises >= pre) begin
            k   = rises - pre;
            rsp = 8 / bpl(rx_m);
            idx = split ? frames - 1 : k / rsp;
            sub = k % rsp;
            if (idx >= 0 && idx < 8) begin
                b = seq[idx] << (bpl(rx_m) * sub);
                case (rx_m)
                    2'd0:    io_in = {2'b00, b[7], 1'b0};
                    2'd1:    io_in = {2'b00, b[7:6]};
                    default: io_in = b[7:4];
                endcase
            end
        end
    end

    int st_chg = 0, dcnt = 0;
    logic [7:0] prev_st = 8'd0;
    always @(negedge clk) begin
        if (poll_status != prev_st) st_chg++;
        prev_st = poll_status;
        if (poll_done) dcnt++;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic make_seq(input int nb);
        nbusy = nb;
        for (int i = 0; i < 8; i++) begin
            logic [7:0] b;
            b = 8'($urandom);
            b[pos] = (i < nb) ? lvl : !lvl;
            seq[i] = b;
        end
    endtask

    task automatic run(input bit inject);
        int lat, cyc, exp_lat, exp_chg, exp_rises, rsp;
        logic [7:0] prv;
        prv = poll_status;
        exp_chg = 0;
        for (int i = 0; i <= nbusy; i++) begin
            if (seq[i] != prv) exp_chg++;
            prv = seq[i];
        end
        rsp = 8 / bpl(rx_m);
        exp_rises = split ? (nbusy + 1) * (pre_slots() + rsp)
                          : pre_slots() + (nbusy + 1) * rsp;
        exp_lat = (erase && dly != 0) ? int'(dly) : 0;
        frames = 0; tot_rises = 0; op_err = 0; dmy_err = 0; oe_err = 0;
        st_chg = 0; dcnt = 0;
        @(negedge clk); start = 1'b1; after_erase = erase;
        @(negedge clk); start = 1'b0; after_erase = 1'b0;
        lat = 0;
        while (spi_cs_n && lat < 400) begin @(negedge clk); lat++; end
        chk(lat == exp_lat, "R9 hold-off latency", lat, exp_lat);
        cyc = 0;
        while (!poll_done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (inject && cyc == 7) begin start = 1'b1; after_erase = 1'b1; end
            if (cyc == 8) begin start = 1'b0; after_erase = 1'b0; end
        end
        chk(poll_done == 1'b1, "R8 done seen", poll_done, 1);
        chk(spi_cs_n == 1'b1, "R8 cs high with done", spi_cs_n, 1);
        chk(poll_status == seq[nbusy], "R5 idle status byte", poll_status, seq[nbusy]);
        repeat (10) @(negedge clk);
        chk(dcnt == 1, "R8 single done pulse", dcnt, 1);
        chk(poll_busy == 1'b0, "R10 no restart from extra request", poll_busy, 0);
        if (split) begin
            chk(frames == nbusy + 1, "R7 frame count", frames, nbusy + 1);
            chk(tot_rises == exp_rises, "R7 clock count", tot_rises, exp_rises);
        end else begin
            chk(frames == 1, "R6 frame count", frames, 1);
            chk(tot_rises == exp_rises, "R6 clock count", tot_rises, exp_rises);
        end
        chk(op_err == 0, "R2 opcode and lanes", op_err, 0);
        chk(dmy_err == 0, "R3 dummy phase", dmy_err, 0);
        chk(oe_err == 0, "R4 receive lanes released", oe_err, 0);
        chk(st_chg == exp_chg, "R11 status updates", st_chg, exp_chg);
    endtask

    initial begin
        void'($urandom(32'd5150));
        for (int i = 0; i < 8; i++) seq[i] = 8'hFF;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(spi_cs_n == 1'b1, "R1 cs", spi_cs_n, 1);
        chk(spi_sck == 1'b0, "R1 sck", spi_sck, 0);
        chk(spi_io_oe == 4'd0, "R1 oe", spi_io_oe, 0);
        chk(poll_done == 1'b0 && poll_busy == 1'b0, "R1 done/busy", poll_done, 0);
        chk(poll_status == 8'd0, "R1 status", poll_status, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // directed: single lanes, idle at once, no dummy
        opc = 8'h05; cmd_m = 0; rx_m = 0; pos = 0; lvl = 1; den = 0; split = 0;
        erase = 0; dly = 0; make_seq(0); run(0);
        // directed: quad, 16 dummy bytes of ones, bit 7 busy low, continuous
        opc = 8'hA7; cmd_m = 2; rx_m = 3; pos = 7; lvl = 0; den = 1; dnum = 15;
        dval = 1; make_seq(3); run(0);
        // directed: maximum hold-off, split, dual
        cmd_m = 1; rx_m = 1; pos = 3; lvl = 1; den = 1; dnum = 0; dval = 0;
        split = 1; erase = 1; dly = 7'd127; make_seq(2); run(0);
        // directed: erase flag with zero delay
        erase = 1; dly = 0; split = 0; make_seq(1); run(0);
        // directed: extra request mid-poll
        erase = 0; cmd_m = 0; rx_m = 2; make_seq(3); run(1);

        for (int t = 0; t < 40; t++) begin
            opc   = 8'($urandom);
            cmd_m = 2'($urandom);
            rx_m  = 2'($urandom);
            pos   = 3'($urandom);
            lvl   = 1'($urandom);
            den   = 1'($urandom);
            dnum  = 4'($urandom % 4);
            dval  = 1'($urandom);
            split = 1'($urandom);
            erase = 1'($urandom);
            dly   = 7'($urandom % 40);
            make_seq(int'($urandom % 5));
            run(1'($urandom));
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule